// File: doc/BRIEF.md
# Folded-Window Band Sequencer

This controller walks a fixed list of spectral analysis bands, one band at a time, and drives a shared multiply-accumulate datapath that folds each band's window around its first sample. For every butterfly it issues the input-sample addresses of a converging pair (n and N−n), the coefficient address of the cosine/sine pair, and strobes that mark the first butterfly (single sample, zero partner) and the last one. The accumulator clear and the result write strobes are delayed to line up with the datapath pipeline. The real and imaginary results of a band land at two adjacent result-memory words.

The window length of each band is computed from parameters when the design is elaborated: a run of equal-width low bands uses the full frame, and each higher band shortens the window by a fixed ratio. A per-band table derived from that rule holds the window length, the index of the last butterfly, the window parity and the coefficient base. Outside a transform the block acts as an I/O address generator: one strobe loads the next sample address of a frame, the other reads the next result word.

Top module: `band_fold_seq`

## Requirements
- R1: After reset, busy, done, rd_en, rd_hi_en, bfly_first, bfly_last, acc_clr, res_we, smp_we and res_rd_en are all low.
- R2: A start accepted while idle issues one butterfly per cycle from the cycle after the start is sampled, band 0 through band NUM_BANDS−1 in order with no gap. Band k has window length N(k): FRAME_LEN for k < LIN_BANDS, otherwise max(2, floor(N(k−1)·RATIO_NUM/RATIO_DEN)); it takes floor(N(k)/2)+1 butterflies with indices n = 0 upward.
- R3: Butterfly 0 of every band reads only sample address 0: rd_lo_addr = 0, bfly_first = 1, rd_hi_en = 0.
- R4: Butterfly n ≥ 1 reads the pair rd_lo_addr = n and rd_hi_addr = N−n with rd_hi_en = 1, except as stated in R5.
- R5: For even N the last butterfly (n = N/2) reads only the middle sample, with rd_hi_en = 0; for odd N the last butterfly still reads a pair.
- R6: bfly_last is high exactly on butterfly n = floor(N/2).
- R7: coef_addr equals the sum of the butterfly counts of all earlier bands plus n, so the coefficient addresses run contiguously from 0.
- R8: acc_clr rises ACC_LAT cycles after each bfly_first; res_we rises WR_LAT cycles after each bfly_last, with res_waddr_re = 2k and res_waddr_im = 2k+1 for band k.
- R9: done is a one-cycle pulse coinciding with the res_we of the final band; busy is high from the cycle after the start is sampled through the done cycle.
- R10: A start while busy has no effect on the running sequence.
- R11: While idle, each io_wr gives smp_we in the next cycle with smp_waddr stepping 0,1,… and wrapping after FRAME_LEN−1; each io_rd gives res_rd_en next cycle with res_rd_addr wrapping after 2·NUM_BANDS−1.
- R12: io_wr and io_rd are ignored while busy and in the cycle a start is accepted; an accepted start resets both I/O addresses to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a transform |
| io_wr | input | 1 | Request next sample write address |
| io_rd | input | 1 | Request next result read address |
| busy | output | 1 | Transform in progress |
| done | output | 1 | Final band result written |
| smp_we | output | 1 | Sample memory write enable |
| smp_waddr | output | AW | Sample memory write address |
| res_rd_en | output | 1 | Result memory read enable |
| res_rd_addr | output | OUT_AW | Result memory read address |
| rd_en | output | 1 | Butterfly issue valid, low sample read |
| rd_lo_addr | output | AW | Low (ascending) sample address n |
| rd_hi_en | output | 1 | Partner sample read valid |
| rd_hi_addr | output | AW | High (descending) sample address N−n |
| coef_addr | output | COEF_AW | Coefficient pair address |
| bfly_first | output | 1 | First butterfly, zero partner |
| bfly_last | output | 1 | Last butterfly of band |
| acc_clr | output | 1 | Accumulator clear, pipeline aligned |
| res_we | output | 1 | Result write enable, pipeline aligned |
| res_waddr_re | output | OUT_AW | Real result write address |
| res_waddr_im | output | OUT_AW | Imaginary result write address |

## Verification
Issue outputs appear in the cycle after the edge that samples start and advance one butterfly per cycle, so the bench numbers cycles from that edge and checks every issue cycle against a schedule it builds from the window-length rule. The clear strobe is due ACC_LAT cycles and the write strobe and done WR_LAT cycles after the issue that caused them; the bench places those in the same schedule at those offsets. I/O strobes take effect one cycle later, and the bench samples every output at the falling edge so each value is read mid-cycle, well clear of the edge that produced it.

// File: rtl/bandseq_pkg.sv
`timescale 1ns/1ps
package bandseq_pkg;

  // Window length of band k: full frame for the linear bands, then a
  // fixed-ratio shrink per band, never below two samples.
  function automatic int win_len(int k, int nlin, int frame, int rnum, int rden);
    int n;
    n = frame;
    for (int i = nlin; i <= k; i++) begin
      n = (n * rnum) / rden;
      if (n < 2) n = 2;
    end
    return n;
  endfunction

  // First coefficient address of band k (sum of earlier butterfly counts).
  function automatic int coef_base(int k, int nlin, int frame, int rnum, int rden);
    int s;
    s = 0;
    for (int j = 0; j < k; j++)
      s += win_len(j, nlin, frame, rnum, rden) / 2 + 1;
    return s;
  endfunction

endpackage

// File: rtl/band_table.sv
`timescale 1ns/1ps
module band_table #(
  parameter int NUM_BANDS = 21,
  parameter int LIN_BANDS = 5,
  parameter int FRAME_LEN = 160,
  parameter int RATIO_NUM = 27,
  parameter int RATIO_DEN = 32,
  parameter int AW        = 8,
  parameter int BAND_W    = 5,
  parameter int COEF_AW   = 10
) (
  input  logic [BAND_W-1:0]  band,
  output logic [AW-1:0]      nlen,
  output logic [AW-1:0]      last_idx,
  output logic               odd,
  output logic [COEF_AW-1:0] base_nxt
);
  logic [AW-1:0]      len_tab  [NUM_BANDS];
  logic [COEF_AW-1:0] base_tab [NUM_BANDS+1];

  for (genvar k = 0; k < NUM_BANDS; k++) begin : g_len
    assign len_tab[k] = AW'(bandseq_pkg::win_len(k, LIN_BANDS, FRAME_LEN, RATIO_NUM, RATIO_DEN));
  end
  for (genvar k = 0; k <= NUM_BANDS; k++) begin : g_base
    assign base_tab[k] = COEF_AW'(bandseq_pkg::coef_base(k, LIN_BANDS, FRAME_LEN, RATIO_NUM, RATIO_DEN));
  end

  assign nlen     = len_tab[band];
  assign last_idx = nlen >> 1;
  assign odd      = nlen[0];
  assign base_nxt = base_tab[(BAND_W+1)'(band) + (BAND_W+1)'(1)];
endmodule

// File: rtl/fold_issue.sv
`timescale 1ns/1ps
module fold_issue #(
  parameter int NUM_BANDS = 21,
  parameter int AW        = 8,
  parameter int BAND_W    = 5,
  parameter int COEF_AW   = 10
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               go,
  input  logic [AW-1:0]      nlen,
  input  logic [AW-1:0]      last_idx,
  input  logic               odd,
  input  logic [COEF_AW-1:0] base_nxt,
  output logic [BAND_W-1:0]  band,
  output logic               iss_valid,
  output logic               iss_first,
  output logic               iss_last,
  output logic               iss_pair,
  output logic               iss_final,
  output logic [AW-1:0]      lo,
  output logic [AW-1:0]      hi,
  output logic [COEF_AW-1:0] coef
);
  logic active;

  assign iss_valid = active;
  assign iss_first = active && (lo == '0);
  assign iss_last  = active && (lo == last_idx);
  assign iss_pair  = active && (lo != '0) && !(iss_last && !odd);
  assign iss_final = iss_last && (band == BAND_W'(NUM_BANDS-1));

  always_ff @(posedge clk) begin
    if (rst) begin
      active <= 1'b0;
      band   <= '0;
      lo     <= '0;
      hi     <= '0;
      coef   <= '0;
    end else if (go) begin
      active <= 1'b1;
      band   <= '0;
      lo     <= '0;
      hi     <= '0;
      coef   <= '0;
    end else if (active) begin
      if (iss_last) begin
        if (iss_final) begin
          active <= 1'b0;
        end else begin
          band <= band + BAND_W'(1);
          lo   <= '0;
          hi   <= '0;
          coef <= base_nxt;
        end
      end else begin
        lo   <= lo + AW'(1);
        hi   <= (lo == '0) ? nlen - AW'(1) : hi - AW'(1);
        coef <= coef + COEF_AW'(1);
      end
    end
  end

  AST_LO_ASCENDS: assert property (@(posedge clk) disable iff (rst)
    (iss_valid && !iss_first && $past(iss_valid)) |-> lo == $past(lo) + AW'(1)); // R4
  AST_HI_DESCENDS: assert property (@(posedge clk) disable iff (rst)
    (iss_valid && lo > AW'(1) && $past(iss_valid)) |-> hi == $past(hi) - AW'(1)); // R4
  AST_PAIR_ORDER: assert property (@(posedge clk) disable iff (rst)
    iss_pair |-> lo < hi); // R5
  AST_COEF_CONTIG: assert property (@(posedge clk) disable iff (rst)
    (iss_valid && $past(iss_valid)) |-> coef == $past(coef) + COEF_AW'(1)); // R7
  AST_BAND_AFTER_LAST: assert property (@(posedge clk) disable iff (rst)
    (iss_first && $past(iss_valid)) |-> $past(iss_last)); // R6
endmodule

// File: rtl/strobe_pipe.sv
`timescale 1ns/1ps
module strobe_pipe #(
  parameter int W     = 1,
  parameter int DEPTH = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] stg [DEPTH];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) stg[i] <= '0;
    end else begin
      stg[0] <= din;
      for (int i = 1; i < DEPTH; i++) stg[i] <= stg[i-1];
    end
  end

  assign dout = stg[DEPTH-1];
endmodule

// File: rtl/wrap_addr.sv
`timescale 1ns/1ps
module wrap_addr #(
  parameter int LIMIT = 160,
  parameter int W     = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         step,
  output logic         en,
  output logic [W-1:0] addr
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      en   <= 1'b0;
      addr <= '0;
    end else begin
      en <= step;
      if (clr) begin
        cnt <= '0;
      end else if (step) begin
        addr <= cnt;
        cnt  <= (cnt == W'(LIMIT-1)) ? '0 : cnt + W'(1);
      end
    end
  end
endmodule

// File: rtl/band_fold_seq.sv
`timescale 1ns/1ps
module band_fold_seq #(
  parameter int NUM_BANDS = 21,
  parameter int LIN_BANDS = 5,
  parameter int FRAME_LEN = 160,
  parameter int RATIO_NUM = 27,
  parameter int RATIO_DEN = 32,
  parameter int ACC_LAT   = 3,
  parameter int WR_LAT    = 4,
  localparam int AW         = $clog2(FRAME_LEN+1),
  localparam int BAND_W     = $clog2(NUM_BANDS),
  localparam int OUT_AW     = BAND_W + 1,
  localparam int COEF_TOTAL = bandseq_pkg::coef_base(NUM_BANDS, LIN_BANDS, FRAME_LEN, RATIO_NUM, RATIO_DEN),
  localparam int COEF_AW    = $clog2(COEF_TOTAL)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  input  logic               io_wr,
  input  logic               io_rd,
  output logic               busy,
  output logic               done,
  output logic               smp_we,
  output logic [AW-1:0]      smp_waddr,
  output logic               res_rd_en,
  output logic [OUT_AW-1:0]  res_rd_addr,
  output logic               rd_en,
  output logic [AW-1:0]      rd_lo_addr,
  output logic               rd_hi_en,
  output logic [AW-1:0]      rd_hi_addr,
  output logic [COEF_AW-1:0] coef_addr,
  output logic               bfly_first,
  output logic               bfly_last,
  output logic               acc_clr,
  output logic               res_we,
  output logic [OUT_AW-1:0]  res_waddr_re,
  output logic [OUT_AW-1:0]  res_waddr_im
);
  logic               go;
  logic [BAND_W-1:0]  band;
  logic [AW-1:0]      nlen, last_idx;
  logic               odd, iss_final;
  logic [COEF_AW-1:0] base_nxt;
  logic [BAND_W+1:0]  wr_in, wr_out;

  assign go = start && !busy;

  band_table #(
    .NUM_BANDS(NUM_BANDS), .LIN_BANDS(LIN_BANDS), .FRAME_LEN(FRAME_LEN),
    .RATIO_NUM(RATIO_NUM), .RATIO_DEN(RATIO_DEN),
    .AW(AW), .BAND_W(BAND_W), .COEF_AW(COEF_AW)
  ) u_tab (
    .band(band), .nlen(nlen), .last_idx(last_idx), .odd(odd), .base_nxt(base_nxt)
  );

  fold_issue #(
    .NUM_BANDS(NUM_BANDS), .AW(AW), .BAND_W(BAND_W), .COEF_AW(COEF_AW)
  ) u_iss (
    .clk(clk), .rst(rst), .go(go),
    .nlen(nlen), .last_idx(last_idx), .odd(odd), .base_nxt(base_nxt),
    .band(band), .iss_valid(rd_en), .iss_first(bfly_first), .iss_last(bfly_last),
    .iss_pair(rd_hi_en), .iss_final(iss_final),
    .lo(rd_lo_addr), .hi(rd_hi_addr), .coef(coef_addr)
  );

  strobe_pipe #(.W(1), .DEPTH(ACC_LAT)) u_clr (
    .clk(clk), .rst(rst), .din(bfly_first), .dout(acc_clr)
  );

  assign wr_in = {bfly_last, iss_final, band};
  strobe_pipe #(.W(BAND_W+2), .DEPTH(WR_LAT)) u_wr (
    .clk(clk), .rst(rst), .din(wr_in), .dout(wr_out)
  );

  assign res_we       = wr_out[BAND_W+1];
  assign done         = wr_out[BAND_W+1] && wr_out[BAND_W];
  assign res_waddr_re = {wr_out[BAND_W-1:0], 1'b0};
  assign res_waddr_im = {wr_out[BAND_W-1:0], 1'b1};

  always_ff @(posedge clk) begin
    if (rst)       busy <= 1'b0;
    else if (go)   busy <= 1'b1;
    else if (done) busy <= 1'b0;
  end

  wrap_addr #(.LIMIT(FRAME_LEN), .W(AW)) u_smp (
    .clk(clk), .rst(rst), .clr(go), .step(io_wr && !busy && !start),
    .en(smp_we), .addr(smp_waddr)
  );

  wrap_addr #(.LIMIT(2*NUM_BANDS), .W(OUT_AW)) u_res (
    .clk(clk), .rst(rst), .clr(go), .step(io_rd && !busy && !start),
    .en(res_rd_en), .addr(res_rd_addr)
  );

  AST_IO_QUIET: assert property (@(posedge clk) disable iff (rst)
    busy |-> (!smp_we && !res_rd_en)); // R12
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R9
  AST_ISSUE_BUSY: assert property (@(posedge clk) disable iff (rst)
    rd_en |-> busy); // R9
  AST_WRITE_BUSY: assert property (@(posedge clk) disable iff (rst)
    res_we |-> busy); // R8
endmodule

// File: tb/sim_band_fold_seq.sv
`timescale 1ns/1ps
module sim_band_fold_seq;
  localparam int NB   = 21;
  localparam int NLIN = 5;
  localparam int FR   = 160;
  localparam int RN   = 27;
  localparam int RD   = 32;
  localparam int ACC  = 3;
  localparam int WRL  = 4;
  localparam int MAXC = 2048;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0, io_wr = 1'b0, io_rd = 1'b0;
  logic busy, done, smp_we, res_rd_en, rd_en, rd_hi_en, bfly_first, bfly_last, acc_clr, res_we;
  logic [7:0] smp_waddr, rd_lo_addr, rd_hi_addr;
  logic [5:0] res_rd_addr, res_waddr_re, res_waddr_im;
  logic [9:0] coef_addr;

  int nvec = 0, nfail = 0;
  int e_val [MAXC], e_lo [MAXC], e_hi [MAXC], e_pair [MAXC], e_first [MAXC];
  int e_last [MAXC], e_coef [MAXC], e_even_last [MAXC], e_clr [MAXC], e_we [MAXC], e_wband [MAXC];
  int total, dcyc;

  always #10 clk = ~clk;

  band_fold_seq u0 (
    .clk(clk), .rst(rst), .start(start), .io_wr(io_wr), .io_rd(io_rd),
    .busy(busy), .done(done), .smp_we(smp_we), .smp_waddr(smp_waddr),
    .res_rd_en(res_rd_en), .res_rd_addr(res_rd_addr), .rd_en(rd_en),
    .rd_lo_addr(rd_lo_addr), .rd_hi_en(rd_hi_en), .rd_hi_addr(rd_hi_addr),
    .coef_addr(coef_addr), .bfly_first(bfly_first), .bfly_last(bfly_last),
    .acc_clr(acc_clr), .res_we(res_we), .res_waddr_re(res_waddr_re),
    .res_waddr_im(res_waddr_im)
  );

  task automatic chk(input string tag, input int act, input int exp);
    nvec++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s act=%0d exp=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  // Schedule from the window-length rule of R2.
  task automatic build_schedule();
    int n, c;
    n = FR;
    c = 0;
    for (int i = 0; i < MAXC; i++) begin
      e_val[i] = 0; e_clr[i] = 0; e_we[i] = 0; e_even_last[i] = 0;
    end
    for (int k = 0; k < NB; k++) begin
      if (k >= NLIN) begin
        n = (n * RN) / RD;
        if (n < 2) n = 2;
      end
      for (int b = 0; b <= n / 2; b++) begin
        e_val[c]   = 1;
        e_lo[c]    = b;
        e_hi[c]    = n - b;
        e_first[c] = (b == 0);
        e_last[c]  = (b == n / 2);
        e_even_last[c] = (b == n / 2) && (n % 2 == 0);
        e_pair[c]  = (b != 0) && !e_even_last[c];
        e_coef[c]  = c;
        if (b == 0) e_clr[c + ACC] = 1;
        if (b == n / 2) begin
          e_we[c + WRL]    = 1;
          e_wband[c + WRL] = k;
        end
        c++;
      end
    end
    total = c;
    dcyc  = total - 1 + WRL;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

  initial begin
    build_schedule();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    step();
    // R1: reset state
    chk("R1 busy", busy, 0);       chk("R1 done", done, 0);
    chk("R1 rd_en", rd_en, 0);     chk("R1 rd_hi_en", rd_hi_en, 0);
    chk("R1 first", bfly_first, 0); chk("R1 last", bfly_last, 0);
    chk("R1 acc_clr", acc_clr, 0); chk("R1 res_we", res_we, 0);
    chk("R1 smp_we", smp_we, 0);   chk("R1 res_rd_en", res_rd_en, 0);

    // R11: sample write address sweep with wrap
    io_wr = 1'b1;
    for (int i = 0; i < FR + 3; i++) begin
      step();
      chk("R11 smp_we", smp_we, 1);
      chk("R11 smp_waddr", smp_waddr, i % FR);
    end
    io_wr = 1'b0;
    step();
    chk("R11 smp_we idle", smp_we, 0);

    // R11: result read address sweep with wrap
    io_rd = 1'b1;
    for (int i = 0; i < 2 * NB + 2; i++) begin
      step();
      chk("R11 res_rd_en", res_rd_en, 1);
      chk("R11 res_rd_addr", res_rd_addr, i % (2 * NB));
    end
    io_rd = 1'b0;
    step();
    chk("R11 res_rd_en idle", res_rd_en, 0);

    // Transform run with I/O strobes held high and a second start mid-run.
    start = 1'b1; io_wr = 1'b1; io_rd = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    for (int c = 0; c <= dcyc + 2; c++) begin
      if (e_val[c] != 0) begin
        chk("R2 rd_en", rd_en, 1);
        chk("R6 bfly_last", bfly_last, e_last[c]);
        chk("R7 coef_addr", coef_addr, e_coef[c]);
        if (e_first[c] != 0) begin
          chk("R3 bfly_first", bfly_first, 1);
          chk("R3 rd_lo_addr", rd_lo_addr, 0);
          chk("R3 rd_hi_en", rd_hi_en, 0);
        end else begin
          chk("R2 bfly_first", bfly_first, 0);
          chk("R4 rd_lo_addr", rd_lo_addr, e_lo[c]);
          if (e_even_last[c] != 0) chk("R5 rd_hi_en even", rd_hi_en, 0);
          else                     chk("R4 rd_hi_en", rd_hi_en, 1);
          if (e_pair[c] != 0)      chk("R4 rd_hi_addr", rd_hi_addr, e_hi[c]);
        end
      end else begin
        chk("R2 rd_en idle", rd_en, 0);
      end
      chk("R8 acc_clr", acc_clr, e_clr[c]);
      chk("R8 res_we", res_we, e_we[c]);
      if (e_we[c] != 0) begin
        chk("R8 res_waddr_re", res_waddr_re, 2 * e_wband[c]);
        chk("R8 res_waddr_im", res_waddr_im, 2 * e_wband[c] + 1);
      end
      chk("R9 done", done, (c == dcyc) ? 1 : 0);
      chk("R10 busy", busy, (c <= dcyc) ? 1 : 0);
      chk("R12 smp_we", smp_we, (c == dcyc + 2) ? 1 : 0);
      chk("R12 res_rd_en", res_rd_en, (c == dcyc + 2) ? 1 : 0);
      if (c == dcyc + 2) begin
        chk("R12 smp_waddr cleared", smp_waddr, 0);
        chk("R12 res_rd_addr cleared", res_rd_addr, 0);
      end
      start = (c == 50) ? 1'b1 : 1'b0;  // R10: ignored while busy
      if (c == dcyc + 2) begin
        io_wr = 1'b0; io_rd = 1'b0;
      end
      step();
    end
    chk("R9 busy after run", busy, 0);
    chk("R2 rd_en after run", rd_en, 0);

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end
endmodule